// File: doc/BRIEF.md
# Dual-Mode Fractional/Integer Multiplier

This block multiplies two 16-bit data words in one pass and presents a 40-bit product ready to be added into a DSP accumulator. Each operand has its own signed/unsigned select. Before the multiply, each operand is widened to 17 bits. A signed operand gets a sign extension and an unsigned operand gets a zero extension. One 17x17 signed array then covers every mix of operand types.

A mode select picks how the product is presented:
- **Integer mode:** the product is a plain integer.
- **Fractional mode:** the product is doubled so that the binary point sits after bit 31, which gives a 1.31 value. The one product that cannot be represented is the most negative value times itself with both operands signed. That case is clamped to the largest positive 1.31 value.

In both modes the upper bits are sign-filled out to 40 bits. The same unit serves ordinary integer multiplies and multiply-accumulate work. A parameter adds an optional output register.

Top module: `mul17_dual`

## Requirements
- R1: With both operands unsigned (`a_signed_i`=0, `b_signed_i`=0) and `frac_i`=0, `p_o` equals the exact product of the two operands read as values 0..65535, so bit 39 is 0.
- R2: With `frac_i`=0 and both operands signed, `p_o` equals the exact two's-complement product, sign-extended to 40 bits.
- R3: With `frac_i`=1, `p_o[31:0]` holds the low 32 bits of the exact product shifted left by one bit, so bit 0 is 0. Bits 39..32 are each a copy of bit 31.
- R4: With `frac_i`=1, both selects at 1 and both operands 16'h8000, `p_o` equals 40'h007FFFFFFF.
- R5: Each operand's select acts on that operand only. A mixed pair (one signed, one unsigned) yields the exact product of a two's-complement value and a value in 0..65535, sign-extended to 40 bits.
- R6: With `REG_OUT`=1, `p_o` shows the result for the inputs present at the latest rising clock edge. While `rst_n` is low, `p_o` is 0, and this takes effect without waiting for a clock.
- R7: With `REG_OUT`=0, `p_o` follows the inputs combinationally, with no clock delay.
- R8: An operand equal to zero gives `p_o` = 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_signed_i | input | 1 | 1: `a_i` is two's complement, 0: unsigned |
| b_signed_i | input | 1 | 1: `b_i` is two's complement, 0: unsigned |
| frac_i | input | 1 | 1: fractional 1.31 result, 0: integer result |
| p_o | output | 40 | Sign-filled product |

## Verification
The bench builds two instances side by side, both with the default operand width of 16 bits.
- The `REG_OUT`=1 instance brings the one-cycle capture within reach, together with the reset clearing that does not wait for a clock.
- The `REG_OUT`=0 instance exposes the combinational path, which is checked in the same cycle the inputs change.

Both instances see directed corner operands (0, 1, 16'h7FFF, 16'h8000, 16'hFFFF) in all eight select combinations, including the clamped fractional case. These are followed by pseudo-random operands under every mode.

// File: rtl/mul17_dual.sv
module mul17_dual #(
  parameter int OPW     = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPW-1:0]      a_i,
  input  logic [OPW-1:0]      b_i,
  input  logic                a_signed_i,
  input  logic                b_signed_i,
  input  logic                frac_i,
  output logic [2*OPW+7:0]    p_o
);
  localparam int XW = OPW + 1;
  localparam int PW = 2 * XW;
  localparam int RW = 2 * OPW;
  localparam int AW = RW + 8;
  localparam logic [OPW-1:0] MIN_OP = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [AW-1:0]  MAX_Q  = {{(AW-RW+1){1'b0}}, {(RW-1){1'b1}}};

  logic signed [XW-1:0] ax, bx;
  logic signed [PW-1:0] prod;
  logic        [RW-1:0] fw;
  logic                 sat;
  logic        [AW-1:0] res;

  assign ax   = {a_signed_i & a_i[OPW-1], a_i};
  assign bx   = {b_signed_i & b_i[OPW-1], b_i};
  assign prod = ax * bx;
  assign fw   = {prod[RW-2:0], 1'b0};
  assign sat  = frac_i & a_signed_i & b_signed_i & (a_i == MIN_OP) & (b_i == MIN_OP);

  always_comb begin
    if (sat)         res = MAX_Q;
    else if (frac_i) res = {{(AW-RW){fw[RW-1]}}, fw};
    else             res = {{(AW-PW){prod[PW-1]}}, prod};
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_o <= '0;
        else        p_o <= res;
      end
    end else begin : g_comb
      assign p_o = res;
    end
  endgenerate

  // R1: two unsigned operands in integer mode never give a negative result
  p_unsigned_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frac_i && !a_signed_i && !b_signed_i) |-> !res[AW-1]);

  // R3: fractional results are sign-filled above bit 31 and have an even LSB
  p_frac_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_i && !sat) |-> (res[AW-1:RW-1] == {(AW-RW+1){res[RW-1]}} && !res[0]));

  // R4: the most negative value squared is clamped in fractional mode
  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_i && a_signed_i && b_signed_i && a_i == MIN_OP && b_i == MIN_OP) |-> (res == MAX_Q));

  // R8: a zero operand yields zero
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i == '0 || b_i == '0) |-> (res == '0));

  // R2: a signed pair in integer mode has a product whose sign follows the operand signs
  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frac_i && a_signed_i && b_signed_i && a_i != '0 && b_i != '0) |->
      (res[AW-1] == (a_i[OPW-1] ^ b_i[OPW-1])));
endmodule

// File: tb/mul17_dual_tb_top.sv
module mul17_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        sa = 1'b0, sb = 1'b0, fr = 1'b0;
  logic [39:0] p_reg, p_cmb;
  int          errors = 0, checks = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  mul17_dual #(.OPW(16), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .a_signed_i(sa), .b_signed_i(sb),
    .frac_i(fr), .p_o(p_reg));

  mul17_dual #(.OPW(16), .REG_OUT(1'b0)) dut_comb_i (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .a_signed_i(sa), .b_signed_i(sb),
    .frac_i(fr), .p_o(p_cmb));

  function automatic logic [39:0] model(logic [15:0] x, logic [15:0] y,
                                        logic xs, logic ys, logic f);
    longint xv, yv, pv;
    logic [63:0] w;
    xv = xs ? longint'($signed(x)) : longint'({48'd0, x});
    yv = ys ? longint'($signed(y)) : longint'({48'd0, y});
    pv = xv * yv;
    if (f) begin
      if (xs && ys && x == 16'h8000 && y == 16'h8000) return 40'h007FFFFFFF;
      w  = 64'(pv * 2);
      pv = longint'($signed(w[31:0]));
    end
    w = 64'(pv);
    return w[39:0];
  endfunction

  function automatic string tag_of(logic [15:0] x, logic [15:0] y,
                                   logic xs, logic ys, logic f);
    if (x == 0 || y == 0) return "R8";
    if (f) return (xs && ys && x == 16'h8000 && y == 16'h8000) ? "R4" : "R3";
    if (xs != ys) return "R5";
    return xs ? "R2" : "R1";
  endfunction

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h sa=%b sb=%b fr=%b)",
               req, act, exp, a, b, sa, sb, fr);
    end
  endtask

  // Called at a falling edge: the inputs were held across the previous rising edge.
  task automatic step(logic [15:0] x, logic [15:0] y, logic xs, logic ys, logic f);
    logic [39:0] e;
    string t;
    e = model(a, b, sa, sb, fr);
    t = tag_of(a, b, sa, sb, fr);
    check({t, "/R6 registered"}, p_reg, e);
    a = x; b = y; sa = xs; sb = ys; fr = f;
    #1;
    check({tag_of(x, y, xs, ys, f), "/R7 combinational"}, p_cmb, model(x, y, xs, ys, f));
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [15:0] corners [5];
    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'hFFFF;
    a = 16'h1234; b = 16'h5678;
    repeat (3) @(negedge clk);
    check("R6 reset", p_reg, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);
    a = '0; b = '0;
    @(negedge clk);
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          step(corners[i], corners[j], m[0], m[1], m[2]);
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[15:0], lfsr[31:16] ^ 16'(n), lfsr[3], lfsr[17], lfsr[9]);
    end
    step(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1);
    step(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1);
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    step(16'h7FFF, 16'h8000, 1'b1, 1'b1, 1'b0);
    step(16'h0003, 16'h0005, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R6 async reset", p_reg, 40'h0);
    @(negedge clk);
    check("R6 held in reset", p_reg, 40'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule